// File: doc/BRIEF.md
# Configurable Clock Output Divider

This block turns a fast internal clock into one output clock. The output ratio comes from a 2-bit divide-mode field and a 10-bit value Q. The stage can hold the divided signal low, pass the input clock straight through, halve it, or divide it by Q + 2. Two complete sets of mode and Q are presented at the inputs, and a select input picks the one in use. A new set, a new mode or a new polarity is adopted only when the divided output starts a new period, so the output never shows a runt pulse.

When the output is disabled it either floats or is held at a fixed level, as a 2-bit idle-state field chooses. A separate drive-enable output is provided for the external tri-state pad driver. Enabling and disabling also wait until the divided signal is in its low phase. An inversion bit sets the polarity of the running clock.

Top module: `clk_out_divider`

## Requirements
- R1: The active mode picks the behaviour: 00 keeps the divided signal low, 01 passes the input clock through, 10 divides by 2, and 11 divides by Q+2 with a 10-bit Q, which gives ratios from 2 to 1025.
- R2: Each divided period of N input cycles begins with a high phase of floor(N/2) input cycles. The remaining cycles of the period are low.
- R3: cfg_sel selects set 1 (mode1, q1) when it is 1 and set 0 (mode0, q0) when it is 0. In modes 10 and 11 a changed set, mode or Q is adopted at the input edge that starts the next divided period. In modes 00 and 01 it is adopted at the next input edge.
- R4: After reset the active settings are mode 11 with Q=2, and the counter is at the start of a high phase. The first rising edge of the divided output therefore comes at the 4th input edge after reset. clk_out and drv_en are low while reset is applied.
- R5: The output is enabled only when oe_in is 1 and both mode0 and mode1 are non-zero. Otherwise it is in its disabled state.
- R6: The idle field sets the disabled state. 0x gives drv_en=0 and clk_out=0. 10 gives drv_en=1 with clk_out held at 0. 11 gives drv_en=1 with clk_out held at 1. While the output is enabled, drv_en=1.
- R7: A change of enable or idle state is applied on an input clock edge, and only on an edge after which the divided signal is low. It is never applied during a high phase.
- R8: invert=1 inverts the enabled output. The bit is taken up together with the other settings, as R3 describes.
- R9: In mode 01 with the output enabled, clk_out equals clk_in XOR the inversion bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Selects configuration set 0 or 1 |
| mode0 | input | 2 | Divide mode of set 0 |
| q0 | input | 10 | Divider value Q of set 0 |
| mode1 | input | 2 | Divide mode of set 1 |
| q1 | input | 10 | Divider value Q of set 1 |
| oe_in | input | 1 | Output enable request |
| idle_sel | input | 2 | Disabled-state field (0x float, 10 low, 11 high) |
| invert | input | 1 | Output polarity |
| clk_out | output | 1 | Divided clock |
| drv_en | output | 1 | Enable for the external tri-state driver |

## Verification
On every cycle the assertions check several invariants. The counter stays inside the current ratio. Rising edges of the divided signal happen only at a period start. Active settings change only at the end of a divided period. The enable cannot rise unless both modes are non-zero. Enable and idle state never change during a high phase, and a floated output is low. Only the bench scenarios can show the duty split for odd ratios and the delayed default period after reset. The same holds for the exact cycle in which a set switch or polarity change appears, the output levels of each idle state, and the pass-through waveform within a single input cycle.

// File: rtl/clk_out_divider.sv
module clk_out_divider #(
  parameter int QW = 10
) (
  input  logic          clk_in,
  input  logic          rst_n,
  input  logic          cfg_sel,
  input  logic [1:0]    mode0,
  input  logic [QW-1:0] q0,
  input  logic [1:0]    mode1,
  input  logic [QW-1:0] q1,
  input  logic          oe_in,
  input  logic [1:0]    idle_sel,
  input  logic          invert,
  output logic          clk_out,
  output logic          drv_en
);
  localparam int CW = QW + 1;

  function automatic logic [CW-1:0] ratio_of(input logic [1:0] m, input logic [QW-1:0] q);
    if (m == 2'b10) return CW'(2);
    return CW'(q) + CW'(2);
  endfunction

  logic [1:0]    act_mode;
  logic [QW-1:0] act_q;
  logic          inv_st;
  logic [CW-1:0] cnt;
  logic          div_q;
  logic          en_st;
  logic [1:0]    idle_st;

  wire [1:0]    sel_mode = cfg_sel ? mode1 : mode0;
  wire [QW-1:0] sel_q    = cfg_sel ? q1 : q0;
  wire [CW-1:0] ratio    = ratio_of(act_mode, act_q);
  wire          wrap     = !act_mode[1] || (cnt == ratio - CW'(1));
  wire          en_req   = oe_in && (mode0 != 2'b00) && (mode1 != 2'b00);

  logic [1:0]    nxt_mode;
  logic [QW-1:0] nxt_q;
  logic [CW-1:0] nxt_cnt;
  logic [CW-1:0] nxt_ratio;
  logic          nxt_div;

  always_comb begin
    nxt_mode  = wrap ? sel_mode : act_mode;
    nxt_q     = wrap ? sel_q : act_q;
    nxt_cnt   = wrap ? '0 : cnt + CW'(1);
    nxt_ratio = ratio_of(nxt_mode, nxt_q);
    nxt_div   = nxt_mode[1] && (nxt_cnt < (nxt_ratio >> 1));
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= 2'b11;
      act_q    <= QW'(2);
      inv_st   <= 1'b0;
      cnt      <= '0;
      div_q    <= 1'b1;
      en_st    <= 1'b0;
      idle_st  <= 2'b00;
    end else begin
      act_mode <= nxt_mode;
      act_q    <= nxt_q;
      cnt      <= nxt_cnt;
      div_q    <= nxt_div;
      if (wrap) inv_st <= invert;
      if (!nxt_div) begin
        en_st   <= en_req;
        idle_st <= idle_sel;
      end
    end
  end

  wire base = (act_mode == 2'b01) ? clk_in : div_q;

  assign clk_out = en_st ? (inv_st ^ base) : (idle_st[1] & idle_st[0]);
  assign drv_en  = en_st | idle_st[1];
endmodule

module clk_out_divider_chk #(
  parameter int QW = 10
) (
  input logic          clk_in,
  input logic          rst_n,
  input logic [1:0]    mode0,
  input logic [1:0]    mode1,
  input logic          oe_in,
  input logic [1:0]    act_mode,
  input logic [QW-1:0] act_q,
  input logic [QW:0]   cnt,
  input logic [QW:0]   ratio,
  input logic          div_q,
  input logic          en_st,
  input logic [1:0]    idle_st,
  input logic          clk_out,
  input logic          drv_en
);
  assert_cnt_in_range_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt < ratio);

  assert_rise_at_start_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(div_q) |-> cnt == '0);

  assert_switch_at_wrap_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
    ($past(act_mode[1]) && (act_mode != $past(act_mode) || act_q != $past(act_q)))
      |-> ($past(cnt) == $past(ratio) - 1'b1));

  assert_enable_gated_R5: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(en_st) |-> $past(oe_in && mode0 != 2'b00 && mode1 != 2'b00));

  assert_float_low_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
    !drv_en |-> !clk_out);

  assert_no_change_in_high_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!$stable(en_st) || !$stable(idle_st)) |-> !div_q);
endmodule

bind clk_out_divider clk_out_divider_chk #(.QW(QW)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .mode0(mode0), .mode1(mode1), .oe_in(oe_in),
  .act_mode(act_mode), .act_q(act_q), .cnt(cnt), .ratio(ratio), .div_q(div_q),
  .en_st(en_st), .idle_st(idle_st), .clk_out(clk_out), .drv_en(drv_en)
);

// File: tb/clk_out_divider_bench.sv
module clk_out_divider_bench;
  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 1'b0;
  logic [1:0] mode0 = 2'b10, mode1 = 2'b10;
  logic [9:0] q0 = '0, q1 = '0;
  logic oe_in = 1'b1;
  logic [1:0] idle_sel = 2'b00;
  logic invert = 1'b0;
  logic clk_out, drv_en;

  int vectors = 0;
  int fails = 0;
  string tag = "R4";

  logic [1:0] m_mode;
  logic [9:0] m_q;
  logic m_inv, m_div, m_en;
  logic [1:0] m_idle;
  int m_cnt;

  always #2.5 clk_in = ~clk_in;

  clk_out_divider u_clk_out_divider (
    .clk_in(clk_in), .rst_n(rst_n), .cfg_sel(cfg_sel), .mode0(mode0), .q0(q0),
    .mode1(mode1), .q1(q1), .oe_in(oe_in), .idle_sel(idle_sel), .invert(invert),
    .clk_out(clk_out), .drv_en(drv_en)
  );

  function automatic int ratio_of(input logic [1:0] m, input logic [9:0] q);
    return (m == 2'b10) ? 2 : int'(q) + 2;
  endfunction

  function automatic logic exp_out(input logic clk_level);
    if (m_en) return m_inv ^ ((m_mode == 2'b01) ? clk_level : m_div);
    return m_idle[1] & m_idle[0];
  endfunction

  task automatic check(input logic act_o, input logic exp_o, input logic act_d, input logic exp_d);
    vectors++;
    if (act_o !== exp_o || act_d !== exp_d) begin
      fails++;
      $display("FAIL %s: clk_out=%b drv_en=%b expected clk_out=%b drv_en=%b at %0t",
               tag, act_o, act_d, exp_o, exp_d, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 2'b11; m_q = 10'd2; m_inv = 1'b0; m_cnt = 0;
    m_div = 1'b1; m_en = 1'b0; m_idle = 2'b00;
  endtask

  task automatic model_step();
    if (!m_mode[1] || m_cnt == ratio_of(m_mode, m_q) - 1) begin
      m_mode = cfg_sel ? mode1 : mode0;
      m_q = cfg_sel ? q1 : q0;
      m_inv = invert;
      m_cnt = 0;
    end else m_cnt++;
    m_div = m_mode[1] && (m_cnt < ratio_of(m_mode, m_q) / 2);
    if (!m_div) begin
      m_en = oe_in && mode0 != 2'b00 && mode1 != 2'b00;
      m_idle = idle_sel;
    end
  endtask

  task automatic cycle();
    @(posedge clk_in);
    model_step();
    if (m_en && m_mode == 2'b01) begin
      #1;
      check(clk_out, exp_out(1'b1), drv_en, 1'b1);
    end
    @(negedge clk_in);
    check(clk_out, exp_out(1'b0), drv_en, m_en | m_idle[1]);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    // R4: reset state, then default ratio 4 before first rise
    repeat (3) begin
      @(negedge clk_in);
      check(clk_out, 1'b0, drv_en, 1'b0);
    end
    rst_n = 1'b1;
    tag = "R4";
    run(8);

    tag = "R1"; mode0 = 2'b11; mode1 = 2'b11; q0 = 10'd0; run(12);
    tag = "R2"; q0 = 10'd1; run(15);
    q0 = 10'd3; run(20);
    q0 = 10'd6; run(24);

    tag = "R3"; q1 = 10'd2; mode1 = 2'b10;
    run(3); cfg_sel = 1'b1; run(9); cfg_sel = 1'b0; run(2); q0 = 10'd4; run(14);

    tag = "R1"; q0 = 10'd1023; run(2100);

    tag = "R5"; q0 = 10'd3; run(12); mode1 = 2'b00; run(14); mode1 = 2'b11; run(14);
    tag = "R6"; oe_in = 1'b0; idle_sel = 2'b10; run(12);
    idle_sel = 2'b11; run(12);
    idle_sel = 2'b00; run(12);
    tag = "R7"; oe_in = 1'b1; run(2); oe_in = 1'b0; idle_sel = 2'b11; run(3);
    oe_in = 1'b1; run(12);
    tag = "R8"; invert = 1'b1; run(2); invert = 1'b0; run(4); invert = 1'b1; run(14);
    tag = "R9"; mode0 = 2'b01; run(10); invert = 1'b0; run(6); oe_in = 1'b0; run(4);
    oe_in = 1'b1; mode0 = 2'b11; run(10);

    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 19) == 0) cfg_sel = $urandom_range(0, 1);
      if ($urandom_range(0, 39) == 0) mode0 = ($urandom_range(0, 7) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      if ($urandom_range(0, 39) == 0) mode1 = ($urandom_range(0, 7) == 0) ? 2'b00 : 2'($urandom_range(1, 3));
      if ($urandom_range(0, 29) == 0) q0 = 10'($urandom_range(0, 7));
      if ($urandom_range(0, 29) == 0) q1 = 10'($urandom_range(0, 7));
      if ($urandom_range(0, 49) == 0) oe_in = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 49) == 0) idle_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 49) == 0) invert = $urandom_range(0, 1);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule